// File: doc/BRIEF.md
# Dual-Halfword and High-Word Signed Multiply-Accumulate Unit

This unit performs two families of signed multiplication on 32-bit operands. In dual mode it splits both operands into halfwords and forms two 16×16 signed products. The products are added or subtracted, and the result is accumulated into a 64-bit value given as a high word and a low word. In high-word mode it forms the full 64-bit signed product of the two operands. It can then fold that product into an accumulator that sits in the upper word, either by adding or by reverse-subtracting. Rounding is optional, and the unit returns the upper 32 bits.

The unit is a two-stage pipeline. Stage one selects the operand halves and forms the products. Stage two accumulates and rounds. A start strobe may arrive on every cycle, and each start yields one done pulse two cycles later. The results stay on the outputs until the next done pulse replaces them.

Top module: `dhmac_unit`

## Requirements
- R1: In dual mode (`mode_i`=0) the products are signed(A[15:0])×signed(B'[15:0]) and signed(A[31:16])×signed(B'[31:16]). B' is B with its two halfwords exchanged when `swap_i`=1, and B unchanged otherwise.
- R2: In dual mode, `sub_i`=0 sums the two products and `sub_i`=1 takes the low-half product minus the high-half product.
- R3: In dual mode, the sign-extended product sum is added to {`acc_hi_i`,`acc_lo_i`} modulo 2^64. The new upper word appears on `res_hi_o` and the new lower word on `res_lo_o`. The sum loses nothing even when both products are 2^30.
- R4: In high-word mode (`mode_i`=1) the full 64-bit signed product of A and B is formed. `res_hi_o` carries bits 63:32 of the final value and `res_lo_o` is zero.
- R5: In high-word mode with `acc_en_i`=1, the final value is ({`acc_hi_i`,32'h0} + product) when `sub_i`=0, and ({`acc_hi_i`,32'h0} − product) when `sub_i`=1. With `acc_en_i`=0 the product alone is used and `sub_i` has no effect.
- R6: In high-word mode with `round_i`=1, 0x80000000 is added to the 64-bit value before its upper word is taken.
- R7: `done_o` is high for exactly one cycle, two clock cycles after each cycle in which `start_i` is high. A start is accepted on every cycle, and back-to-back starts each return their own result.
- R8: `res_hi_o` and `res_lo_o` keep their value in every cycle in which `done_o` is low.
- R9: While reset is asserted, and after it is released until the first result, `done_o`, `res_hi_o` and `res_lo_o` are zero.
- R10: `swap_i` has no effect in high-word mode. `round_i` and `acc_en_i` have no effect in dual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts an operation on the operands present in this cycle |
| mode_i | input | 1 | 0 = dual halfword long, 1 = high word |
| swap_i | input | 1 | Exchanges the halfwords of B (dual mode) |
| sub_i | input | 1 | Subtract select |
| round_i | input | 1 | Round select (high-word mode) |
| acc_en_i | input | 1 | Accumulate enable (high-word mode) |
| a_i | input | DW | Operand A |
| b_i | input | DW | Operand B |
| acc_hi_i | input | DW | Accumulator upper word |
| acc_lo_i | input | DW | Accumulator lower word (dual mode) |
| res_hi_o | output | DW | Result upper word |
| res_lo_o | output | DW | Result lower word |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench builds the unit with its default word width, DW=32, so halfwords are 16 bits and the accumulator is 64 bits. At this width the bench can reach the extreme products: two 2^30 halfword products that need a 33rd bit, 64-bit accumulator wrap-around, and the most negative 32-bit operand pair in high-word mode. It can also reach the rounding carry that crosses into the upper word. Back-to-back starts with mixed modes test whether the mode and select controls stay aligned with their operands through both stages.

// File: rtl/dhmac_pkg.sv
package dhmac_pkg;
  typedef enum logic {
    MODE_DUAL = 1'b0,
    MODE_HIGH = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/dhmac_prod_stage.sv
// Stage 1: operand half selection and product formation.
module dhmac_prod_stage
  import dhmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_i,
  input  logic            mode_i,
  input  logic            swap_i,
  input  logic            sub_i,
  input  logic            rnd_i,
  input  logic            acc_en_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [DW-1:0]   acc_hi_i,
  input  logic [DW-1:0]   acc_lo_i,
  output logic            vld_o,
  output logic            mode_o,
  output logic            sub_o,
  output logic            rnd_o,
  output logic            acc_en_o,
  output logic [DW-1:0]   acc_hi_o,
  output logic [DW-1:0]   acc_lo_o,
  output logic [DW-1:0]   p_lo_o,
  output logic [DW-1:0]   p_hi_o,
  output logic [2*DW-1:0] p_wide_o
);
  localparam int HW = DW / 2;
  localparam int PW = 2 * DW;

  logic [DW-1:0] b_sel;
  logic [DW-1:0] a_lo_x, a_hi_x, b_lo_x, b_hi_x;
  logic [DW-1:0] p_lo_d, p_hi_d;
  logic [PW-1:0] p_wide_d;
  logic          vld_q;

  // next-state logic
  always_comb begin
    b_sel = b_i;
    if (mode_i == MODE_DUAL && swap_i) begin
      b_sel = {b_i[HW-1:0], b_i[DW-1:HW]};
    end
    a_lo_x   = {{HW{a_i[HW-1]}},   a_i[HW-1:0]};
    a_hi_x   = {{HW{a_i[DW-1]}},   a_i[DW-1:HW]};
    b_lo_x   = {{HW{b_sel[HW-1]}}, b_sel[HW-1:0]};
    b_hi_x   = {{HW{b_sel[DW-1]}}, b_sel[DW-1:HW]};
    p_lo_d   = a_lo_x * b_lo_x;
    p_hi_d   = a_hi_x * b_hi_x;
    p_wide_d = {{DW{a_i[DW-1]}}, a_i} * {{DW{b_i[DW-1]}}, b_i};
  end

  // valid register with asynchronous reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_i;
  end

  // datapath registers, loaded only when an operation enters
  always_ff @(posedge clk) begin
    if (vld_i) begin
      mode_o   <= mode_i;
      sub_o    <= sub_i;
      rnd_o    <= rnd_i;
      acc_en_o <= acc_en_i;
      acc_hi_o <= acc_hi_i;
      acc_lo_o <= acc_lo_i;
      p_lo_o   <= p_lo_d;
      p_hi_o   <= p_hi_d;
      p_wide_o <= p_wide_d;
    end
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/dhmac_acc_stage.sv
// Stage 2: product combine, accumulate, round, select result words.
module dhmac_acc_stage
  import dhmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_i,
  input  logic            mode_i,
  input  logic            sub_i,
  input  logic            rnd_i,
  input  logic            acc_en_i,
  input  logic [DW-1:0]   acc_hi_i,
  input  logic [DW-1:0]   acc_lo_i,
  input  logic [DW-1:0]   p_lo_i,
  input  logic [DW-1:0]   p_hi_i,
  input  logic [2*DW-1:0] p_wide_i,
  output logic [DW-1:0]   res_hi_o,
  output logic [DW-1:0]   res_lo_o,
  output logic            done_o
);
  localparam int PW = 2 * DW;
  localparam int SW = DW + 2;
  localparam logic [PW-1:0] RND_K = {{DW{1'b0}}, 1'b1, {(DW-1){1'b0}}};

  logic [SW-1:0] e_lo, e_hi, dsum;
  logic [PW-1:0] dual_val, acc_sh, hw_acc, hw_val;
  logic [DW-1:0] hi_nxt, lo_nxt;
  logic          done_q;

  // next-state logic
  always_comb begin
    e_lo     = {{2{p_lo_i[DW-1]}}, p_lo_i};
    e_hi     = {{2{p_hi_i[DW-1]}}, p_hi_i};
    dsum     = sub_i ? (e_lo - e_hi) : (e_lo + e_hi);
    dual_val = {{(PW-SW){dsum[SW-1]}}, dsum} + {acc_hi_i, acc_lo_i};

    acc_sh   = {acc_hi_i, {DW{1'b0}}};
    hw_acc   = sub_i ? (acc_sh - p_wide_i) : (acc_sh + p_wide_i);
    hw_val   = acc_en_i ? hw_acc : p_wide_i;
    if (rnd_i) hw_val = hw_val + RND_K;

    if (mode_i == MODE_HIGH) begin
      hi_nxt = hw_val[PW-1:DW];
      lo_nxt = '0;
    end else begin
      hi_nxt = dual_val[PW-1:DW];
      lo_nxt = dual_val[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      res_hi_o <= '0;
      res_lo_o <= '0;
    end else begin
      done_q <= vld_i;
      if (vld_i) begin
        res_hi_o <= hi_nxt;
        res_lo_o <= lo_nxt;
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/dhmac_unit.sv
module dhmac_unit
  import dhmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic          swap_i,
  input  logic          sub_i,
  input  logic          round_i,
  input  logic          acc_en_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] acc_hi_i,
  input  logic [DW-1:0] acc_lo_i,
  output logic [DW-1:0] res_hi_o,
  output logic [DW-1:0] res_lo_o,
  output logic          done_o
);
  localparam int PW = 2 * DW;

  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic          s1_vld, s1_mode, s1_sub, s1_rnd, s1_acc_en;
  logic [DW-1:0] s1_acc_hi, s1_acc_lo, s1_p_lo, s1_p_hi;
  logic [PW-1:0] s1_p_wide;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  dhmac_prod_stage #(.DW(DW)) u_prod (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .vld_i    (start_i),
    .mode_i   (mode_i),
    .swap_i   (swap_i),
    .sub_i    (sub_i),
    .rnd_i    (round_i),
    .acc_en_i (acc_en_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .acc_hi_i (acc_hi_i),
    .acc_lo_i (acc_lo_i),
    .vld_o    (s1_vld),
    .mode_o   (s1_mode),
    .sub_o    (s1_sub),
    .rnd_o    (s1_rnd),
    .acc_en_o (s1_acc_en),
    .acc_hi_o (s1_acc_hi),
    .acc_lo_o (s1_acc_lo),
    .p_lo_o   (s1_p_lo),
    .p_hi_o   (s1_p_hi),
    .p_wide_o (s1_p_wide)
  );

  dhmac_acc_stage #(.DW(DW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .vld_i    (s1_vld),
    .mode_i   (s1_mode),
    .sub_i    (s1_sub),
    .rnd_i    (s1_rnd),
    .acc_en_i (s1_acc_en),
    .acc_hi_i (s1_acc_hi),
    .acc_lo_i (s1_acc_lo),
    .p_lo_i   (s1_p_lo),
    .p_hi_i   (s1_p_hi),
    .p_wide_i (s1_p_wide),
    .res_hi_o (res_hi_o),
    .res_lo_o (res_lo_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/dhmac_unit_chk.sv
module dhmac_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          start_i,
  input logic          mode_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] acc_hi_i,
  input logic [DW-1:0] acc_lo_i,
  input logic [DW-1:0] res_hi_o,
  input logic [DW-1:0] res_lo_o,
  input logic          done_o
);
  logic st_d1, st_d2, md_d1, md_d2;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_d1 <= 1'b0; st_d2 <= 1'b0;
      md_d1 <= 1'b0; md_d2 <= 1'b0;
    end else begin
      st_d1 <= start_i; st_d2 <= st_d1;
      md_d1 <= mode_i;  md_d2 <= md_d1;
    end
  end

  // R7: done follows each start by two cycles
  p_done_latency_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o == st_d2);

  // R8: results hold while no done
  p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done_o |-> ($stable(res_hi_o) && $stable(res_lo_o)));

  // R4: high-word result leaves the low word at zero
  p_high_lo_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && md_d2) |-> (res_lo_o == '0));

  // R3: zero A in dual mode returns the accumulator unchanged
  p_zero_operand_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !mode_i && a_i == '0) |=> ##1
      (res_hi_o == $past(acc_hi_i, 2) && res_lo_o == $past(acc_lo_i, 2)));
endmodule

bind dhmac_unit dhmac_unit_chk #(.DW(DW)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .a_i        (a_i),
  .acc_hi_i   (acc_hi_i),
  .acc_lo_i   (acc_lo_i),
  .res_hi_o   (res_hi_o),
  .res_lo_o   (res_lo_o),
  .done_o     (done_o)
);

// File: tb/dhmac_unit_tb_top.sv
`timescale 1ns/1ps
module dhmac_unit_tb_top;
  typedef struct packed {
    logic        mode, swap, sub, rnd, acc;
    logic [31:0] a, b, hi, lo;
  } op_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, mode_i, swap_i, sub_i, round_i, acc_en_i;
  logic [31:0] a_i, b_i, acc_hi_i, acc_lo_i;
  logic [31:0] res_hi_o, res_lo_o;
  logic        done_o;
  int          checks = 0;
  int          failures = 0;

  always #2 clk = ~clk;

  dhmac_unit #(.DW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .swap_i(swap_i), .sub_i(sub_i), .round_i(round_i), .acc_en_i(acc_en_i),
    .a_i(a_i), .b_i(b_i), .acc_hi_i(acc_hi_i), .acc_lo_i(acc_lo_i),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .done_o(done_o)
  );

  function automatic logic [63:0] model(op_t o);
    logic [31:0] bb;
    longint p1, p2, s, v, base;
    if (!o.mode) begin
      bb = o.swap ? {o.b[15:0], o.b[31:16]} : o.b;
      p1 = longint'($signed(o.a[15:0]))  * longint'($signed(bb[15:0]));
      p2 = longint'($signed(o.a[31:16])) * longint'($signed(bb[31:16]));
      s  = o.sub ? (p1 - p2) : (p1 + p2);
      return 64'(s) + {o.hi, o.lo};
    end
    p1   = longint'($signed(o.a)) * longint'($signed(o.b));
    base = longint'({o.hi, 32'h0});
    v    = o.acc ? (o.sub ? (base - p1) : (base + p1)) : p1;
    if (o.rnd) v = v + 64'sh80000000;
    return {v[63:32], 32'h0};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(op_t o, logic st);
    start_i = st; mode_i = o.mode; swap_i = o.swap; sub_i = o.sub;
    round_i = o.rnd; acc_en_i = o.acc; a_i = o.a; b_i = o.b;
    acc_hi_i = o.hi; acc_lo_i = o.lo;
  endtask

  function automatic op_t mk(logic mode, logic swap, logic sub, logic rnd,
                             logic acc, logic [31:0] a, logic [31:0] b,
                             logic [31:0] hi, logic [31:0] lo);
    op_t o;
    o.mode = mode; o.swap = swap; o.sub = sub; o.rnd = rnd; o.acc = acc;
    o.a = a; o.b = b; o.hi = hi; o.lo = lo;
    return o;
  endfunction

  // single operation: drive at a falling edge, result two edges later
  task automatic run_op(string tag, op_t o);
    drive(o, 1'b1);
    @(negedge clk);
    drive(o, 1'b0);
    check("R7 no early done", {63'h0, done_o}, 64'h0);
    @(negedge clk);
    check("R7 done at two cycles", {63'h0, done_o}, 64'h1);
    check(tag, {res_hi_o, res_lo_o}, model(o));
    @(negedge clk);
    check("R7 done single pulse", {63'h0, done_o}, 64'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(mk(0,0,0,0,0,0,0,0,0), 1'b0);
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {res_hi_o, res_lo_o}, 64'h0);
    check("R9 reset done", {63'h0, done_o}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 after release", {done_o, res_hi_o[30:0], res_lo_o}, 64'h0);
  endtask

  task automatic t_dual();
    run_op("R1 dual basic",       mk(0,0,0,0,0, 32'h0003_FFFE, 32'h0005_0007, 32'h0, 32'h10));
    run_op("R1 dual swap",        mk(0,1,0,0,0, 32'h0003_FFFE, 32'h0005_0007, 32'h0, 32'h10));
    run_op("R2 dual subtract",    mk(0,0,1,0,0, 32'h1234_8001, 32'h7FFF_C000, 32'h1, 32'h2));
    run_op("R2 dual swap sub",    mk(0,1,1,0,0, 32'hFFFF_0002, 32'h0003_8000, 32'h0, 32'h0));
    run_op("R3 dual extreme sum", mk(0,0,0,0,0, 32'h8000_8000, 32'h8000_8000, 32'h0, 32'h0));
    run_op("R3 dual extreme sub", mk(0,0,1,0,0, 32'h7FFF_8000, 32'h8000_8000, 32'h0, 32'h0));
    run_op("R3 dual acc wrap",    mk(0,0,0,0,0, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF));
    run_op("R3 dual neg into acc",mk(0,0,0,0,0, 32'h0000_FFFF, 32'h0000_0001, 32'h0000_0001, 32'h0));
  endtask

  task automatic t_high();
    run_op("R4 high product",     mk(1,0,0,0,0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0, 32'hDEAD));
    run_op("R4 high min squared", mk(1,0,0,0,0, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0));
    run_op("R5 high acc add",     mk(1,0,0,0,1, 32'hFFFF_FFFD, 32'h0001_0000, 32'h0000_0010, 32'h0));
    run_op("R5 high acc rsub",    mk(1,0,1,0,1, 32'h4000_0000, 32'h0000_0008, 32'h0000_0003, 32'h0));
    run_op("R5 sub ignored no acc",mk(1,0,1,0,0, 32'h4000_0000, 32'h0000_0008, 32'h0000_0003, 32'h0));
    run_op("R6 round carry",      mk(1,0,0,1,0, 32'h0000_0001, 32'h8000_0000, 32'h0, 32'h0));
    run_op("R6 round acc sub",    mk(1,0,1,1,1, 32'h0000_C000, 32'h0000_C000, 32'h7FFF_FFFF, 32'h0));
  endtask

  task automatic t_ignore();
    run_op("R10 swap ignored high", mk(1,1,0,0,0, 32'h0001_0002, 32'h0003_0004, 32'h0, 32'h0));
    check("R10 swap ignored high value", {res_hi_o, res_lo_o}, 64'h0000_0003_0000_0000);
    run_op("R10 rnd acc ignored dual", mk(0,0,0,1,1, 32'h0002_0003, 32'h0004_0005, 32'h0, 32'h0));
    check("R10 rnd acc ignored dual value", {res_hi_o, res_lo_o}, 64'h0000_0000_0000_0017);
  endtask

  task automatic t_pipeline();
    op_t ops [4];
    ops[0] = mk(0,0,0,0,0, 32'h0010_0020, 32'h0030_0040, 32'h0, 32'h5);
    ops[1] = mk(1,0,0,1,1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h1, 32'h0);
    ops[2] = mk(0,1,1,0,0, 32'hFFF0_0011, 32'h0002_0009, 32'hA, 32'hB);
    ops[3] = mk(1,0,1,0,1, 32'h8000_0000, 32'h0000_0002, 32'h5, 32'h0);
    for (int i = 0; i < 6; i++) begin
      if (i >= 2) begin
        check("R7 back-to-back done", {63'h0, done_o}, 64'h1);
        check("R7 back-to-back result", {res_hi_o, res_lo_o}, model(ops[i-2]));
      end
      if (i < 4) drive(ops[i], 1'b1);
      else       drive(ops[0], 1'b0);
      @(negedge clk);
    end
    check("R7 pipeline drained", {63'h0, done_o}, 64'h0);
  endtask

  task automatic t_hold();
    op_t o;
    logic [63:0] held;
    o = mk(0,0,0,0,0, 32'h0100_0200, 32'h0300_0400, 32'h9, 32'h9);
    run_op("R8 hold setup", o);
    held = model(o);
    for (int i = 0; i < 4; i++) begin
      drive(mk(1,1,1,1,1, 32'hFFFF_0000 + i, 32'h1234_0000, 32'h77, 32'h88), 1'b0);
      @(negedge clk);
      check("R8 outputs held", {res_hi_o, res_lo_o}, held);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(mk(0,0,0,0,0,0,0,0,0), 1'b0);
    @(negedge clk);
    t_reset();
    t_dual();
    t_high();
    t_ignore();
    t_pipeline();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule